// File: doc/BRIEF.md
# Relocatable standby RAM controller

This block sits on a simple synchronous bus and serves a 2 KB on-chip RAM array together with a small block of control registers. The registers occupy a fixed eight-byte window at `REG_BASE`. The array has no address until software writes a base address register. That write places the array on any 2 KB boundary that does not collide with the register window. The base register accepts exactly one write per reset, so code that runs away later cannot move the array.

A master raises `reqValid` with address, size, direction, privilege and write data. It holds the request until the block answers with `ackOut` or `errOut`, and it drops the request in that same cycle. A byte or aligned word transfer takes one bus cycle of two clocks. A long word takes two bus cycles: the upper half comes first at the given address and the lower half follows at address+2. The block ignores any access it must not serve: a user-mode access when supervisor-only is selected, any array access while the standby-power flag is set, or an address outside both windows. An ignored access gets no response and changes nothing.

Top module: `relocSramTop`

## Requirements
- R1: After reset, the control register at `REG_BASE+0` reads 0x0100 and the base register at `REG_BASE+4` reads 0x0001. The array is unmapped, and `ackOut` and `errOut` are low.
- R2: Base register layout: bits [15:3] hold address bits [23:11], bits [2:1] read as zero, and bit 0 is a read-only disable flag. A base write whose field differs from the register window's 2 KB region clears the disable flag, and the array then answers at that base.
- R3: A base write whose field equals the 2 KB region that holds the register window stores the field but leaves the disable flag set, so the array stays unmapped.
- R4: Only the first write to the base register after reset takes effect. Every later write leaves it unchanged until the next reset.
- R5: If the first base write is a byte write to either half (even address = bits [15:8], odd address = bits [7:0]), the other half is locked as well.
- R6: Bit 8 of the control register selects supervisor-only array access (1) or access from both modes (0). In supervisor-only mode, a user-mode (`reqSuper`=0) array access is ignored.
- R7: A byte access or an aligned word access is acknowledged in the second clock after acceptance. Read data is right-justified on `rdData`, with the unused upper bits zero.
- R8: A long word access (`reqSize` 2 or 3) runs two bus cycles and is acknowledged in the fourth clock. Bits [31:16] go to or come from the address, and bits [15:0] go to or come from address+2, wrapping inside the same window.
- R9: In a byte access, an even address selects bits [15:8] of the 16-bit word and an odd address selects bits [7:0]. Only that byte is written, and a byte read returns it on `rdData[7:0]`.
- R10: A word or long access at an odd address, to a target that would otherwise be served, raises `errOut` in the second clock with no `ackOut`, and neither the array nor the registers change.
- R11: While `standbyIn` is high, array accesses are ignored and the array contents are preserved.
- R12: An ignored access produces neither `ackOut` nor `errOut`, keeps `rdDrive` low and `rdData` zero, and leaves the array unchanged. This covers addresses outside both windows.
- R13: The registers answer in either privilege mode, while the array is disabled, and during standby. Reset does not alter the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request, held until acknowledge or error |
| reqAddr | input | ADDR_W | Byte address |
| reqSize | input | 2 | 0 byte, 1 word, 2 or 3 long word |
| reqWrite | input | 1 | 1 write, 0 read |
| reqSuper | input | 1 | 1 supervisor mode, 0 user mode |
| reqWdata | input | 32 | Write data, right-justified |
| standbyIn | input | 1 | Array is on standby power |
| ackOut | output | 1 | Transfer complete |
| errOut | output | 1 | Address error (misaligned) |
| rdDrive | output | 1 | Block drives read data this cycle |
| rdData | output | 32 | Read data, zero when not driven |

## Verification
The bench attacks the write-once lock in three ways: an overlapping first write, a byte-sized first write followed by a write to the other half, and a reset that must reopen the lock. A design that locks only the written half, or that enables the array on an overlapping base, would show a wrong base readback or would answer at an address it must ignore. The bench places long words so that the order of the two halves shows up in word readbacks. It sends misaligned requests and then reads the target back, to catch a design that flags the error but still writes. Standby and privilege filtering are checked cycle by cycle for a missing response. A design that still acknowledges or drives data would fail those checks, and the array is read back afterwards to prove it was preserved.

// File: rtl/relocSramPkg.sv
package relocSramPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_A1,
    ST_A2,
    ST_B1,
    ST_B2,
    ST_E1,
    ST_E2
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic wrEn;
    logic capHi;
    logic capLo;
    logic capWord;
    logic capByte;
    logic byteHi;
    logic srcReg;
  } dpStrobe_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

endpackage

// File: rtl/relocSramCtrl.sv
module relocSramCtrl
  import relocSramPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int ARR_LOG2 = 11,
  parameter logic [ADDR_W-1:0] REG_BASE = 24'hFFFB00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [1:0]            reqSize,
  input  logic                  reqWrite,
  input  logic                  reqSuper,
  input  logic [31:0]           reqWdata,
  input  logic                  standbyIn,
  output logic                  ackOut,
  output logic                  errOut,
  output logic                  rdDrive,
  output dpStrobe_t             strobe,
  output logic [ARR_LOG2-2:0]   wordIdx,
  output logic [15:0]           wrWord,
  output logic [1:0]            byteEn,
  output logic [15:0]           regWord
);

  localparam int FIELD_W = ADDR_W - ARR_LOG2;
  localparam logic [15:0] FIELD_MASK = ~((16'd1 << (16 - FIELD_W)) - 16'd1);
  localparam logic [FIELD_W-1:0] REG_BLK = REG_BASE[ADDR_W-1:ARR_LOG2];
  localparam logic [ARR_LOG2-1:0] HALF_STEP = ARR_LOG2'(2);

  seqState_t state, stateNxt;

  logic        supOnly;
  logic        baseLocked;
  logic        arrDisable;
  logic [15:0] baseWord;
  logic [FIELD_W-1:0] baseField;

  logic        curReg, curWrite, curLong, curByte;
  logic [ARR_LOG2-1:0] curOff;
  logic [31:0] curWdata;

  logic regHit, arrHit, arrAllowed, misal, take;
  logic inSecond, active;
  logic [ARR_LOG2-1:0] halfOff;
  logic [1:0] regOff;
  logic regWr;
  logic [15:0] mergedBase;

  assign baseField = baseWord[15 -: FIELD_W];

  // request decode
  assign regHit     = (reqAddr[ADDR_W-1:3] == REG_BASE[ADDR_W-1:3]);
  assign arrHit     = !arrDisable && (reqAddr[ADDR_W-1:ARR_LOG2] == baseField);
  assign arrAllowed = arrHit && !standbyIn && (reqSuper || !supOnly);
  assign misal      = (reqSize != SZ_BYTE) && reqAddr[0];
  assign take       = reqValid && (regHit || arrAllowed);

  // per-half addressing
  assign inSecond = (state == ST_B1);
  assign active   = (state == ST_A1) || (state == ST_B1);
  assign halfOff  = inSecond ? (curOff + HALF_STEP) : curOff;
  assign regOff   = halfOff[2:1];
  assign wordIdx  = halfOff[ARR_LOG2-1:1];

  always_comb begin
    if (curLong)      wrWord = inSecond ? curWdata[15:0] : curWdata[31:16];
    else if (curByte) wrWord = {curWdata[7:0], curWdata[7:0]};
    else              wrWord = curWdata[15:0];
  end

  assign byteEn = curByte ? (halfOff[0] ? 2'b01 : 2'b10) : 2'b11;

  always_comb begin
    strobe         = '0;
    strobe.wrEn    = active && curWrite && !curReg;
    strobe.capHi   = active && !curWrite && curLong && !inSecond;
    strobe.capLo   = active && !curWrite && curLong && inSecond;
    strobe.capWord = active && !curWrite && !curLong && !curByte;
    strobe.capByte = active && !curWrite && curByte;
    strobe.byteHi  = !halfOff[0];
    strobe.srcReg  = curReg;
  end

  // register read mux
  always_comb begin
    case (regOff)
      2'd0:    regWord = {7'd0, supOnly, 8'd0};
      2'd2:    regWord = baseWord | {15'd0, arrDisable};
      default: regWord = 16'd0;
    endcase
  end

  assign regWr = active && curWrite && curReg;

  always_comb begin
    mergedBase = baseWord;
    if (byteEn[1]) mergedBase[15:8] = wrWord[15:8];
    if (byteEn[0]) mergedBase[7:0]  = wrWord[7:0];
    mergedBase = mergedBase & FIELD_MASK;
  end

  // control and base registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      supOnly    <= 1'b1;
      baseLocked <= 1'b0;
      arrDisable <= 1'b1;
      baseWord   <= 16'd0;
    end else if (regWr) begin
      if (regOff == 2'd0 && byteEn[1]) supOnly <= wrWord[8];
      if (regOff == 2'd2 && !baseLocked) begin
        baseLocked <= 1'b1;
        baseWord   <= mergedBase;
        if (mergedBase[15 -: FIELD_W] != REG_BLK) arrDisable <= 1'b0;
      end
    end
  end

  // sequencer
  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (take) stateNxt = misal ? ST_E1 : ST_A1;
      ST_A1:   stateNxt = ST_A2;
      ST_A2:   stateNxt = curLong ? ST_B1 : ST_IDLE;
      ST_B1:   stateNxt = ST_B2;
      ST_B2:   stateNxt = ST_IDLE;
      ST_E1:   stateNxt = ST_E2;
      ST_E2:   stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curReg   <= 1'b0;
      curWrite <= 1'b0;
      curLong  <= 1'b0;
      curByte  <= 1'b0;
      curOff   <= '0;
      curWdata <= '0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE && take) begin
        curReg   <= regHit;
        curWrite <= reqWrite;
        curLong  <= reqSize[1];
        curByte  <= (reqSize == SZ_BYTE);
        curOff   <= reqAddr[ARR_LOG2-1:0];
        curWdata <= reqWdata;
      end
    end
  end

  assign ackOut  = (state == ST_A2 && !curLong) || (state == ST_B2);
  assign errOut  = (state == ST_E2);
  assign rdDrive = ackOut && !curWrite;

  // R4
  base_lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    baseLocked |=> (baseLocked && $stable(baseWord)));

  // R3
  no_overlap_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !arrDisable |-> (baseField != REG_BLK));

  // R7
  ack_after_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> $past(reqValid, 2));

  // R10
  ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ackOut && errOut));

  // R11
  standby_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid && standbyIn && !regHit) |=> (state == ST_IDLE));

  // R6
  user_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid && !reqSuper && supOnly && !regHit) |=> (state == ST_IDLE));

endmodule

// File: rtl/relocSramData.sv
module relocSramData
  import relocSramPkg::*;
#(
  parameter int ARR_LOG2 = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [ARR_LOG2-2:0] wordIdx,
  input  logic [15:0]         wrWord,
  input  logic [1:0]          byteEn,
  input  logic [15:0]         regWord,
  output logic [31:0]         rdHold
);

  localparam int WORDS = 1 << (ARR_LOG2 - 1);

  logic [15:0] mem [WORDS];
  logic [15:0] srcWord;

  // array contents are never reset
  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      if (byteEn[1]) mem[wordIdx][15:8] <= wrWord[15:8];
      if (byteEn[0]) mem[wordIdx][7:0]  <= wrWord[7:0];
    end
  end

  assign srcWord = strobe.srcReg ? regWord : mem[wordIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdHold <= '0;
    end else begin
      if (strobe.capWord) rdHold <= {16'd0, srcWord};
      if (strobe.capByte) rdHold <= {24'd0, strobe.byteHi ? srcWord[15:8] : srcWord[7:0]};
      if (strobe.capHi)   rdHold[31:16] <= srcWord;
      if (strobe.capLo)   rdHold[15:0]  <= srcWord;
    end
  end

  // R9
  dp_strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrEn, strobe.capHi, strobe.capLo, strobe.capWord, strobe.capByte}));

endmodule

// File: rtl/relocSramTop.sv
module relocSramTop
  import relocSramPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int ARR_LOG2 = 11,
  parameter logic [ADDR_W-1:0] REG_BASE = 24'hFFFB00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic              reqSuper,
  input  logic [31:0]       reqWdata,
  input  logic              standbyIn,
  output logic              ackOut,
  output logic              errOut,
  output logic              rdDrive,
  output logic [31:0]       rdData
);

  dpStrobe_t             strobe;
  logic [ARR_LOG2-2:0]   wordIdx;
  logic [15:0]           wrWord;
  logic [1:0]            byteEn;
  logic [15:0]           regWord;
  logic [31:0]           rdHold;

  relocSramCtrl #(
    .ADDR_W(ADDR_W), .ARR_LOG2(ARR_LOG2), .REG_BASE(REG_BASE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWrite(reqWrite), .reqSuper(reqSuper), .reqWdata(reqWdata),
    .standbyIn(standbyIn),
    .ackOut(ackOut), .errOut(errOut), .rdDrive(rdDrive),
    .strobe(strobe), .wordIdx(wordIdx), .wrWord(wrWord),
    .byteEn(byteEn), .regWord(regWord)
  );

  relocSramData #(
    .ARR_LOG2(ARR_LOG2)
  ) data_i (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .wordIdx(wordIdx), .wrWord(wrWord),
    .byteEn(byteEn), .regWord(regWord), .rdHold(rdHold)
  );

  assign rdData = rdDrive ? rdHold : 32'd0;

endmodule

// File: tb/relocSramTop_tb_top.sv
module relocSramTop_tb_top;

  localparam logic [23:0] RB = 24'hFFFB00;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic        reqSuper = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        standbyIn = 1'b0;
  logic        ackOut, errOut, rdDrive;
  logic [31:0] rdData;

  int checkCnt = 0;
  int failCnt = 0;

  // reference model state
  bit          mSup, mLocked, mDis;
  logic [15:0] mBase;
  logic [15:0] mMem [int];

  always #10 clk = ~clk;

  relocSramTop dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqSuper(reqSuper),
    .reqWdata(reqWdata), .standbyIn(standbyIn),
    .ackOut(ackOut), .errOut(errOut), .rdDrive(rdDrive), .rdData(rdData)
  );

  task automatic check(input string tag, input bit ok, input logic [34:0] act, input logic [34:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual ack/err/drv/data=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mRead(input logic [23:0] a, input bit isReg);
    if (isReg) begin
      if (a[2:1] == 2'd0) return {7'd0, mSup, 8'd0};
      if (a[2:1] == 2'd2) return mBase | {15'd0, mDis};
      return 16'd0;
    end
    return mMem[int'(a[10:1])];
  endfunction

  function automatic void mWrite(input logic [23:0] a, input bit isReg, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] w;
    if (isReg) begin
      if (a[2:1] == 2'd0 && be[1]) mSup = d[8];
      if (a[2:1] == 2'd2 && !mLocked) begin
        w = mBase;
        if (be[1]) w[15:8] = d[15:8];
        if (be[0]) w[7:0] = d[7:0];
        w = w & 16'hFFF8;
        mBase = w;
        mLocked = 1'b1;
        if (w[15:3] != RB[23:11]) mDis = 1'b0;
      end
    end else begin
      w = mMem.exists(int'(a[10:1])) ? mMem[int'(a[10:1])] : 16'h0000;
      if (be[1]) w[15:8] = d[15:8];
      if (be[0]) w[7:0] = d[7:0];
      mMem[int'(a[10:1])] = w;
    end
  endfunction

  task automatic access(input string tag, input logic [23:0] a, input int sz,
                        input bit wr, input bit sup, input logic [31:0] wd);
    bit isReg, arrOk, ok, err, isLong;
    int last;
    logic [23:0] a2;
    logic [31:0] expData;
    bit eAck, eErr, eDrv;
    isReg  = (a[23:3] == RB[23:3]);
    arrOk  = !mDis && (a[23:11] == mBase[15:3]) && !standbyIn && (sup || !mSup);
    ok     = isReg || arrOk;
    err    = ok && (sz != 0) && a[0];
    isLong = (sz >= 2);
    a2     = isReg ? {a[23:3], a[2:0] + 3'd2} : {a[23:11], a[10:0] + 11'd2};
    last   = (!ok) ? 4 : (err ? 2 : (isLong ? 4 : 2));
    expData = '0;
    if (ok && !err && !wr) begin
      if (isLong)      expData = {mRead(a, isReg), mRead(a2, isReg)};
      else if (sz == 1) expData = {16'd0, mRead(a, isReg)};
      else begin
        expData = {24'd0, a[0] ? mRead(a, isReg) >> 0 & 16'h00FF : mRead(a, isReg) >> 8};
      end
    end
    reqAddr = a; reqSize = 2'(sz); reqWrite = wr; reqSuper = sup; reqWdata = wd;
    reqValid = 1'b1;
    for (int c = 1; c <= last; c++) begin
      @(posedge clk); @(negedge clk);
      eAck = ok && !err && (c == last);
      eErr = err && (c == last);
      eDrv = eAck && !wr;
      check(tag,
            (ackOut === eAck) && (errOut === eErr) && (rdDrive === eDrv) &&
            (rdData === (eDrv ? expData : 32'd0)),
            {ackOut, errOut, rdDrive, rdData}, {eAck, eErr, eDrv, eDrv ? expData : 32'd0});
    end
    reqValid = 1'b0;
    if (ok && !err && wr) begin
      if (isLong) begin
        mWrite(a, isReg, wd[31:16], 2'b11);
        mWrite(a2, isReg, wd[15:0], 2'b11);
      end else if (sz == 1) mWrite(a, isReg, wd[15:0], 2'b11);
      else mWrite(a, isReg, {wd[7:0], wd[7:0]}, a[0] ? 2'b01 : 2'b10);
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mSup = 1'b1; mLocked = 1'b0; mDis = 1'b1; mBase = 16'd0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL R7: watchdog expired, actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    doReset();
    check("R1 idle after reset", (ackOut === 1'b0) && (errOut === 1'b0) && (rdDrive === 1'b0),
          {ackOut, errOut, rdDrive, rdData}, 35'd0);
    access("R1 ctrl reset value", RB + 24'd0, 1, 0, 1, 0);
    access("R1 base reset value", RB + 24'd4, 1, 0, 1, 0);
    access("R12 disabled array ignored", 24'h120010, 1, 0, 1, 0);
    // overlapping base then write-once
    access("R3 overlap base write", RB + 24'd4, 1, 1, 1, 32'h0000FFF8);
    access("R3 overlap base readback", RB + 24'd4, 1, 0, 1, 0);
    access("R4 second base write", RB + 24'd4, 1, 1, 1, 32'h00001200);
    access("R4 base unchanged", RB + 24'd4, 1, 0, 1, 0);
    access("R4 array still unmapped", 24'h120010, 1, 0, 1, 0);
    // partial first write
    doReset();
    access("R13 base reopened after reset", RB + 24'd4, 1, 0, 0, 0);
    access("R5 byte write upper half", RB + 24'd4, 0, 1, 1, 32'h00000012);
    access("R5 byte write lower half", RB + 24'd5, 0, 1, 1, 32'h00000034);
    access("R5 R2 base readback", RB + 24'd4, 1, 0, 1, 0);
    access("R2 word write", 24'h120010, 1, 1, 1, 32'h0000A5C3);
    access("R7 word read", 24'h120010, 1, 0, 1, 0);
    access("R6 user write ignored", 24'h120012, 1, 1, 0, 32'h00002222);
    access("R6 user read ignored", 24'h120010, 1, 0, 0, 0);
    access("R13 user ctrl write", RB + 24'd0, 1, 1, 0, 32'h00000000);
    access("R6 ctrl readback", RB + 24'd0, 1, 0, 0, 0);
    access("R6 user read allowed", 24'h120010, 1, 0, 0, 0);
    access("R6 user write allowed", 24'h120012, 1, 1, 0, 32'h00001111);
    access("R6 user write readback", 24'h120012, 1, 0, 1, 0);
    access("R9 byte write even", 24'h120020, 0, 1, 1, 32'h00000077);
    access("R9 byte write odd", 24'h120021, 0, 1, 1, 32'h00000088);
    access("R9 word of bytes", 24'h120020, 1, 0, 1, 0);
    access("R9 byte read odd", 24'h120021, 0, 0, 1, 0);
    access("R9 byte read even", 24'h120020, 0, 0, 0, 0);
    access("R8 long write", 24'h120030, 2, 1, 1, 32'hDEADBEEF);
    access("R8 upper half", 24'h120030, 1, 0, 1, 0);
    access("R8 lower half", 24'h120032, 1, 0, 1, 0);
    access("R8 long read", 24'h120030, 3, 0, 1, 0);
    access("R7 top word write", 24'h1207FE, 1, 1, 1, 32'h00000F0F);
    access("R7 top word read", 24'h1207FE, 1, 0, 1, 0);
    access("R10 misaligned word write", 24'h120011, 1, 1, 1, 32'h0000FFFF);
    access("R10 misaligned long read", 24'h120031, 2, 0, 1, 0);
    access("R10 target unchanged", 24'h120010, 1, 0, 1, 0);
    access("R12 outside above", 24'h130000, 1, 1, 1, 32'h00005555);
    access("R12 outside below", 24'h11FFFE, 1, 0, 1, 0);
    standbyIn = 1'b1;
    access("R11 standby write ignored", 24'h120010, 1, 1, 1, 32'h00000000);
    access("R11 standby read ignored", 24'h120010, 1, 0, 1, 0);
    access("R13 regs in standby", RB + 24'd4, 1, 0, 1, 0);
    standbyIn = 1'b0;
    access("R11 contents preserved", 24'h120010, 1, 0, 1, 0);
    doReset();
    access("R1 unmapped after reset", 24'h120010, 1, 0, 1, 0);
    access("R13 base rewrite", RB + 24'd4, 1, 1, 1, 32'h00001200);
    access("R13 word survives reset", 24'h120010, 1, 0, 1, 0);
    access("R13 long survives reset", 24'h120030, 2, 0, 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule